// File: doc/BRIEF.md
# DRAM Access Cycle Sequencer

This block sits on the bus side of a processor and turns one bus request into the strobe timing of a DRAM access. A request carries an address, a direction, two byte-lane flags and the index of the DRAM area it targets. The block runs a fixed precharge / row / column / column state sequence. During that sequence it drives one of four active-low row strobes, a pair of column strobes on one of two pin pairs, a write enable, and a shared address bus that carries first the row half and then the column half of the address.

Wait states are allowed only between the two column states. Each area has a wait-enable bit, and the bit gates an external wait input. When a DRAM read or write is directly followed by an access to a non-DRAM area, the block inserts one idle state, but only while the column strobes use the write-strobe pins. A refresh request is accepted between bus cycles. It runs a four-state cycle in which the column strobes assert before the row strobes, with a dedicated refresh pin held low.

Top module: `dram_cycle_seq`

## Requirements
- R1: A DRAM access passes through the states PRE, ROW, COL1, COL2 in that order, one clock each when there are no waits. `busPhase` encodes the states as IDLE=0, PRE=1, ROW=2, COL1=3, WAIT=4, COL2=5, GAP=6, EXT=7. After COL2 the block returns to IDLE.
- R2: When the wait-enable bit of the addressed area (bit `reqArea` of `waitEnMask`) is 1, `waitIn` is sampled at the end of COL1 and at the end of each WAIT state. The block stays in WAIT for as many clocks as `waitIn` is seen high, then moves to COL2.
- R3: When the area's wait-enable bit is 0, COL1 is always followed directly by COL2, whatever the level of `waitIn`.
- R4: If a non-DRAM request is accepted in the first IDLE clock after a DRAM read or write, and `colSel` is 0, one GAP state is inserted before the EXT state.
- R5: No GAP state is inserted when `colSel` is 1, when at least one IDLE clock passed without an accepted request, or when the preceding cycle was a refresh. In those cases the non-DRAM request goes straight to EXT.
- R6: With `colSel`=0 the upper and lower column strobes appear on `hwrN`/`lwrN` and `altUcasN`/`altLcasN` stay high. With `colSel`=1 the strobes appear on `altUcasN`/`altLcasN` and `hwrN`/`lwrN` stay high.
- R7: In an access, `rasN[reqArea]` alone is low during ROW, COL1, WAIT and COL2. All row strobes are high in every other state.
- R8: In an access, the upper column strobe is low during WAIT and COL2 only if `reqUpper` was 1. The lower strobe behaves the same way with `reqLower`.
- R9: For a write, `weN` is low from ROW through COL2. For a read it stays high throughout.
- R10: A refresh cycle runs PRE, ROW, COL1, COL2 with no waits. `rfshN` is low in all four states. Both column strobes are low from ROW and all row strobes are low from COL1. `weN` stays high and `muxAddr` is 0.
- R11: `muxAddr` carries the upper half of `reqAddr` during ROW and the lower half during COL1, WAIT and COL2 of an access. It is 0 in every other state.
- R12: A request or refresh is taken only in IDLE. `reqReady` is 1 only in IDLE with `refReq` low. A refresh wins over a request that is pending at the same time.
- R13: After reset the block is in IDLE, every strobe output is high, `muxAddr` is 0 and `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A bus request is presented |
| reqReady | output | 1 | The request is taken at this clock edge |
| reqIsDram | input | 1 | The request targets a DRAM area |
| reqArea | input | 2 | Index of the DRAM area |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqUpper | input | 1 | Upper byte lane accessed |
| reqLower | input | 1 | Lower byte lane accessed |
| reqAddr | input | 16 | Address: upper half is the row, lower half is the column |
| waitEnMask | input | 4 | Per-area permission for column wait states |
| waitIn | input | 1 | External wait request |
| colSel | input | 1 | Selects the pin pair for the column strobes |
| refReq | input | 1 | Refresh request |
| busPhase | output | 3 | Current bus state |
| rasN | output | 4 | Row strobes, one per area, active low |
| hwrN | output | 1 | Upper write-strobe pin, carries the upper column strobe when colSel=0 |
| lwrN | output | 1 | Lower write-strobe pin, carries the lower column strobe when colSel=0 |
| altUcasN | output | 1 | Alternate upper column strobe pin (colSel=1) |
| altLcasN | output | 1 | Alternate lower column strobe pin (colSel=1) |
| weN | output | 1 | Write enable, active low |
| rfshN | output | 1 | Low during a refresh cycle |
| muxAddr | output | 8 | Multiplexed row/column address |

## Verification
The DRAM access is exercised as a read on both lanes with no waits, as a write on one lane with waits enabled, and as a write with `waitIn` held high but waits disabled. These three cases separate the fixed four-state base from the wait extension. The non-DRAM follow-up is tried three ways: directly after a DRAM cycle, after an idle clock, and after a refresh. Each case is run with `colSel` at both values, which separates the GAP rule from plain routing. A refresh is raised together with a pending request, which shows both the arbitration and the refresh strobe order.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_ROW  = 3'd2,
    PH_COL1 = 3'd3,
    PH_WAIT = 3'd4,
    PH_COL2 = 3'd5,
    PH_GAP  = 3'd6,
    PH_EXT  = 3'd7
  } busPhase_e;

  typedef struct packed {
    logic load;     // capture request fields
    logic rasOn;    // row strobe active
    logic rasAll;   // all row strobes (refresh)
    logic casOn;    // column strobes active
    logic casAll;   // both lanes regardless of request (refresh)
    logic weOn;     // write enable window
    logic refOn;    // refresh pin active
    logic addrOn;   // address bus carries row/column
    logic rowAddr;  // 1: row half, 0: column half
  } ctrlStrobe_t;

endpackage

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int NUM_AREAS = 4,
  parameter int AREA_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsDram,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic [NUM_AREAS-1:0] waitEnMask,
  input  logic                 waitIn,
  input  logic                 colSel,
  input  logic                 refReq,
  output busPhase_e            phase,
  output logic                 reqReady,
  output ctrlStrobe_t          strobes
);

  busPhase_e phaseNext;
  logic refCyc, refCycNext;
  logic waitOk, waitOkNext;
  logic lastDram, lastDramNext;
  logic accept;

  assign reqReady = (phase == PH_IDLE) && !refReq;
  assign accept   = reqReady && reqValid;

  always_comb begin
    phaseNext    = phase;
    refCycNext   = refCyc;
    waitOkNext   = waitOk;
    lastDramNext = lastDram;
    case (phase)
      PH_IDLE: begin
        lastDramNext = 1'b0;
        if (refReq) begin
          phaseNext  = PH_PRE;
          refCycNext = 1'b1;
          waitOkNext = 1'b0;
        end else if (reqValid) begin
          if (reqIsDram) begin
            phaseNext  = PH_PRE;
            refCycNext = 1'b0;
            waitOkNext = waitEnMask[reqArea];
          end else if (lastDram && !colSel) begin
            phaseNext = PH_GAP;
          end else begin
            phaseNext = PH_EXT;
          end
        end
      end
      PH_PRE:  phaseNext = PH_ROW;
      PH_ROW:  phaseNext = PH_COL1;
      PH_COL1: phaseNext = (waitOk && waitIn && !refCyc) ? PH_WAIT : PH_COL2;
      PH_WAIT: phaseNext = (waitOk && waitIn) ? PH_WAIT : PH_COL2;
      PH_COL2: begin
        phaseNext    = PH_IDLE;
        lastDramNext = !refCyc;
      end
      PH_GAP:  phaseNext = PH_EXT;
      PH_EXT:  phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      refCyc   <= 1'b0;
      waitOk   <= 1'b0;
      lastDram <= 1'b0;
    end else begin
      phase    <= phaseNext;
      refCyc   <= refCycNext;
      waitOk   <= waitOkNext;
      lastDram <= lastDramNext;
    end
  end

  always_comb begin
    strobes      = '0;
    strobes.load = accept;
    case (phase)
      PH_PRE: strobes.refOn = refCyc;
      PH_ROW: begin
        strobes.rasOn   = !refCyc;
        strobes.casOn   = refCyc;
        strobes.casAll  = refCyc;
        strobes.weOn    = !refCyc;
        strobes.addrOn  = !refCyc;
        strobes.rowAddr = 1'b1;
        strobes.refOn   = refCyc;
      end
      PH_COL1: begin
        strobes.rasOn  = 1'b1;
        strobes.rasAll = refCyc;
        strobes.casOn  = refCyc;
        strobes.casAll = refCyc;
        strobes.weOn   = !refCyc;
        strobes.addrOn = !refCyc;
        strobes.refOn  = refCyc;
      end
      PH_WAIT: begin
        strobes.rasOn  = 1'b1;
        strobes.casOn  = 1'b1;
        strobes.weOn   = 1'b1;
        strobes.addrOn = 1'b1;
      end
      PH_COL2: begin
        strobes.rasOn  = 1'b1;
        strobes.rasAll = refCyc;
        strobes.casOn  = 1'b1;
        strobes.casAll = refCyc;
        strobes.weOn   = !refCyc;
        strobes.addrOn = !refCyc;
        strobes.refOn  = refCyc;
      end
      default: ;
    endcase
  end

  // R1: precharge is followed by the row state, the row state by the first column state
  a_r1_pre_to_row: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_PRE |=> phase == PH_ROW);
  a_r1_row_to_col: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_ROW |=> phase == PH_COL1);
  // R3: waits not permitted -> second column state follows at once
  a_r3_no_wait: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_COL1 && !waitOk) |=> phase == PH_COL2);
  // R4: non-DRAM right after DRAM with write pins as column strobes gets a gap state
  a_r4_gap: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && lastDram && reqValid && !reqIsDram && !refReq && !colSel)
      |=> phase == PH_GAP);
  // R12: refresh taken first when raised in IDLE
  a_r12_ref_first: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && refReq) |=> (phase == PH_PRE && refCyc));

endmodule

// File: rtl/dram_seq_path.sv
module dram_seq_path
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_AREAS = 4,
  parameter int AREA_W    = 2,
  localparam int COL_W    = ADDR_W / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobes,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic                 reqWrite,
  input  logic                 reqUpper,
  input  logic                 reqLower,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 colSel,
  output logic [NUM_AREAS-1:0] rasN,
  output logic                 hwrN,
  output logic                 lwrN,
  output logic                 altUcasN,
  output logic                 altLcasN,
  output logic                 weN,
  output logic                 rfshN,
  output logic [COL_W-1:0]     muxAddr
);

  logic [AREA_W-1:0] areaQ;
  logic              wrQ, upQ, loQ;
  logic [ADDR_W-1:0] addrQ;
  logic              casUp, casLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      areaQ <= '0;
      wrQ   <= 1'b0;
      upQ   <= 1'b0;
      loQ   <= 1'b0;
      addrQ <= '0;
    end else if (strobes.load) begin
      areaQ <= reqArea;
      wrQ   <= reqWrite;
      upQ   <= reqUpper;
      loQ   <= reqLower;
      addrQ <= reqAddr;
    end
  end

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_ras
    assign rasN[g] = !(strobes.rasOn && (strobes.rasAll || areaQ == AREA_W'(g)));
  end

  assign casUp    = strobes.casOn && (strobes.casAll || upQ);
  assign casLo    = strobes.casOn && (strobes.casAll || loQ);
  assign hwrN     = !(casUp && !colSel);
  assign lwrN     = !(casLo && !colSel);
  assign altUcasN = !(casUp && colSel);
  assign altLcasN = !(casLo && colSel);
  assign weN      = !(strobes.weOn && wrQ);
  assign rfshN    = !strobes.refOn;

  always_comb begin
    if (!strobes.addrOn)      muxAddr = '0;
    else if (strobes.rowAddr) muxAddr = addrQ[ADDR_W-1:COL_W];
    else                      muxAddr = addrQ[COL_W-1:0];
  end

  // R7: outside refresh at most one row strobe is low
  a_r7_one_row: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rasAll |-> $countones(~rasN) <= 1);
  // R6: column strobes never appear on both pin pairs at once
  a_r6_one_pair: assert property (@(posedge clk) disable iff (!rstN)
    !((!hwrN || !lwrN) && (!altUcasN || !altLcasN)));
  // R10: refresh pin and write enable are never low together
  a_r10_no_we_in_ref: assert property (@(posedge clk) disable iff (!rstN)
    !rfshN |-> weN);

endmodule

// File: rtl/dram_cycle_seq.sv
module dram_cycle_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_AREAS = 4,
  localparam int AREA_W   = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
  localparam int COL_W    = ADDR_W / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqIsDram,
  input  logic [AREA_W-1:0]    reqArea,
  input  logic                 reqWrite,
  input  logic                 reqUpper,
  input  logic                 reqLower,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [NUM_AREAS-1:0] waitEnMask,
  input  logic                 waitIn,
  input  logic                 colSel,
  input  logic                 refReq,
  output logic [2:0]           busPhase,
  output logic [NUM_AREAS-1:0] rasN,
  output logic                 hwrN,
  output logic                 lwrN,
  output logic                 altUcasN,
  output logic                 altLcasN,
  output logic                 weN,
  output logic                 rfshN,
  output logic [COL_W-1:0]     muxAddr
);

  busPhase_e   phase;
  ctrlStrobe_t strobes;

  dram_seq_ctrl #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsDram(reqIsDram),
    .reqArea(reqArea), .waitEnMask(waitEnMask), .waitIn(waitIn),
    .colSel(colSel), .refReq(refReq), .phase(phase), .reqReady(reqReady),
    .strobes(strobes)
  );

  dram_seq_path #(.ADDR_W(ADDR_W), .NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) i_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqArea(reqArea),
    .reqWrite(reqWrite), .reqUpper(reqUpper), .reqLower(reqLower),
    .reqAddr(reqAddr), .colSel(colSel), .rasN(rasN), .hwrN(hwrN), .lwrN(lwrN),
    .altUcasN(altUcasN), .altLcasN(altLcasN), .weN(weN), .rfshN(rfshN),
    .muxAddr(muxAddr)
  );

  assign busPhase = phase;

endmodule

// File: tb/test_dram_cycle_seq.sv
module test_dram_cycle_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqIsDram = 0, reqWrite = 0, reqUpper = 0, reqLower = 0;
  logic [1:0]  reqArea = 0;
  logic [15:0] reqAddr = 0;
  logic [3:0]  waitEnMask = 4'b0100;
  logic waitIn = 0, colSel = 0, refReq = 0;
  logic reqReady, hwrN, lwrN, altUcasN, altLcasN, weN, rfshN;
  logic [2:0] busPhase;
  logic [3:0] rasN;
  logic [7:0] muxAddr;

  always #5 clk = ~clk;

  dram_cycle_seq i_dram_cycle_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsDram(reqIsDram), .reqArea(reqArea), .reqWrite(reqWrite),
    .reqUpper(reqUpper), .reqLower(reqLower), .reqAddr(reqAddr),
    .waitEnMask(waitEnMask), .waitIn(waitIn), .colSel(colSel), .refReq(refReq),
    .busPhase(busPhase), .rasN(rasN), .hwrN(hwrN), .lwrN(lwrN),
    .altUcasN(altUcasN), .altLcasN(altLcasN), .weN(weN), .rfshN(rfshN),
    .muxAddr(muxAddr)
  );

  typedef struct {
    logic [2:0] ph;
    logic [3:0] ras;
    logic hwr, lwr, au, al, we, rf, rdy;
    logic [7:0] mux;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic exp_t mk(input int ph, input int area, input bit wr, input bit up,
                              input bit lo, input bit rf, input bit cs,
                              input logic [15:0] ad, input string tag);
    exp_t e;
    bit act, cu, cl;
    act = (ph >= 2 && ph <= 5);
    e.ph = 3'(ph);
    e.ras = 4'hF;
    if (rf) begin
      if (ph == 3 || ph == 5) e.ras = 4'h0;
    end else if (act) e.ras[area] = 1'b0;
    if (rf) begin
      cu = (ph == 2 || ph == 3 || ph == 5);
      cl = cu;
    end else begin
      cu = (ph == 4 || ph == 5) && up;
      cl = (ph == 4 || ph == 5) && lo;
    end
    e.hwr = !(cu && !cs);
    e.lwr = !(cl && !cs);
    e.au  = !(cu && cs);
    e.al  = !(cl && cs);
    e.we  = !(!rf && wr && act);
    e.rf  = !(rf && ph >= 1 && ph <= 5);
    if (!rf && ph == 2) e.mux = ad[15:8];
    else if (!rf && act) e.mux = ad[7:0];
    else e.mux = 8'h00;
    e.rdy = (ph == 0);
    e.tag = tag;
    return e;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // monitor: pops one expected item per clock and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, {5'd0, busPhase}, {5'd0, e.ph});
        chk((e.rf == 1'b0 || rfshN == 1'b0) ? "R10 ras" : "R7 ras", {4'd0, rasN}, {4'd0, e.ras});
        chk("R6/R8 cas pins", {4'd0, hwrN, lwrN, altUcasN, altLcasN},
            {4'd0, e.hwr, e.lwr, e.au, e.al});
        chk("R9 weN", {7'd0, weN}, {7'd0, e.we});
        chk("R10 rfshN", {7'd0, rfshN}, {7'd0, e.rf});
        chk("R11 muxAddr", muxAddr, e.mux);
        chk("R12 reqReady", {7'd0, reqReady}, {7'd0, e.rdy});
      end
    end
  end

  task automatic step(input exp_t e);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(mk(0, 0, 0, 0, 0, 0, colSel, 0, "R1 idle"));
  endtask

  task automatic dramOp(input int area, input bit wr, input bit up, input bit lo,
                        input logic [15:0] ad, input int nWait, input string tag);
    int w;
    bit en;
    en = waitEnMask[area];
    reqValid = 1; reqIsDram = 1; reqArea = 2'(area); reqWrite = wr;
    reqUpper = up; reqLower = lo; reqAddr = ad;
    step(mk(1, area, wr, up, lo, 0, colSel, ad, "R1"));
    reqValid = 0; reqAddr = 16'h0000;
    step(mk(2, area, wr, up, lo, 0, colSel, ad, "R1"));
    step(mk(3, area, wr, up, lo, 0, colSel, ad, "R1"));
    w = nWait;
    waitIn = (w > 0);
    while (en && w > 0) begin
      step(mk(4, area, wr, up, lo, 0, colSel, ad, tag));
      w--;
      waitIn = (w > 0);
    end
    step(mk(5, area, wr, up, lo, 0, colSel, ad, tag));
    waitIn = 0;
    step(mk(0, area, wr, up, lo, 0, colSel, ad, "R1"));
  endtask

  task automatic extOp(input bit gap, input string tag);
    reqValid = 1; reqIsDram = 0;
    if (gap) begin
      step(mk(6, 0, 0, 0, 0, 0, colSel, 0, "R4"));
      reqValid = 0;
      step(mk(7, 0, 0, 0, 0, 0, colSel, 0, "R4"));
    end else begin
      step(mk(7, 0, 0, 0, 0, 0, colSel, 0, tag));
      reqValid = 0;
    end
    step(mk(0, 0, 0, 0, 0, 0, colSel, 0, tag));
  endtask

  // refresh raised with a non-DRAM request pending, then that request completes
  task automatic refThenExt();
    refReq = 1; reqValid = 1; reqIsDram = 0;
    step(mk(1, 0, 0, 0, 0, 1, colSel, 0, "R12"));
    refReq = 0;
    waitIn = 1;  // refresh never waits (R10)
    step(mk(2, 0, 0, 0, 0, 1, colSel, 0, "R10"));
    step(mk(3, 0, 0, 0, 0, 1, colSel, 0, "R10"));
    step(mk(5, 0, 0, 0, 0, 1, colSel, 0, "R10"));
    waitIn = 0;
    step(mk(0, 0, 0, 0, 0, 0, colSel, 0, "R12"));
    extOp(0, "R5 after refresh");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R13: reset state
    chk("R13 phase", {5'd0, busPhase}, 8'd0);
    chk("R13 strobes", {rasN, hwrN, lwrN, altUcasN, altLcasN}, 8'hFF);
    chk("R13 misc", {5'd0, weN, rfshN, reqReady}, 8'h07);
    chk("R13 muxAddr", muxAddr, 8'h00);

    dramOp(0, 0, 1, 1, 16'hA55A, 0, "R1 read no wait");
    idle(1);
    dramOp(2, 1, 1, 0, 16'h3C81, 2, "R2 two waits");
    dramOp(1, 1, 0, 1, 16'h7E12, 2, "R3 waits disabled");
    extOp(1, "R4");
    dramOp(2, 0, 1, 1, 16'h0F0F, 0, "R2 enabled no wait");
    idle(2);
    extOp(0, "R5 after idle");
    colSel = 1;
    idle(1);
    dramOp(3, 0, 1, 1, 16'hBEEF, 0, "R6 alt pins");
    extOp(0, "R5 colSel high");
    dramOp(2, 1, 0, 1, 16'h5AC3, 1, "R2 wait alt pins");
    colSel = 0;
    idle(1);
    refThenExt();
    idle(1);

    @(posedge clk); #3;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule